// File: doc/BRIEF.md
# Integer Decode and Execute Stage

This block is the combinational decode and execute step of a 32-bit RISC integer core. It takes one instruction word and the two source register values, which the register file has already read. In the same cycle it returns the destination register index, a write enable, the 32-bit result and three exception flags: illegal instruction, halt and divide-by-zero.

Bit 31 of the instruction selects the format. When it is set, the instruction is register-register. When it is clear, the instruction is register-immediate. Both formats share one 32-entry operation table, indexed by bits 30:26.

The block carries out these operations:
- arithmetic: add, subtract and multiply;
- logic: and, or, xor, xnor and nor;
- the two high-half immediate operations;
- the six compares;
- the three shifts;
- the two sign extensions.

Three hardware options are chosen by parameters: the multiplier, the barrel shifter and the sign extender. A fourth parameter says whether a divider is present. When an option is absent, its instructions raise an illegal-instruction trap.

Loads, stores, branches, calls and control-register instructions pass through without writing a register. The memory, branch and control units handle them.

Top module: `int_exec_stage`

## Requirements
- R1: The destination index comes from bits 15:11 when bit 31 is set (register-register). It comes from bits 20:16 when bit 31 is clear (register-immediate). The low 16 bits are the immediate. Bits 30:26 select the operation from one table shared by both formats.
- R2: No write is made to register 0. `wr_en` is low whenever the destination index is 0.
- R3: The immediate is sign-extended for the following operations:
  - add (code 13);
  - mul (code 2);
  - equal compare (code 25);
  - signed greater compare (code 26);
  - signed greater-or-equal compare (code 27);
  - not-equal compare (code 31).
- R4: The immediate is zero-extended for the following operations:
  - nor (code 1);
  - xor (code 6);
  - and (code 8);
  - xnor (code 9);
  - or (code 14);
  - unsigned greater-or-equal compare (code 28);
  - unsigned greater compare (code 29).
- R5: The register-immediate forms of code 24 (and-high) and code 30 (or-high) use the immediate shifted left by 16 bits.
- R6: A compare writes exactly 1 or 0. Codes 26 and 27 compare signed. Codes 28 and 29 compare unsigned.
- R7: Code 15 shifts left. Code 5 shifts right arithmetically. Code 0 shifts right logically. The register form takes the shift amount from the low 5 bits of the second operand. The immediate form takes it from bits 4:0.
- R8: Without the shifter, a right shift (code 0 or 5) is legal only when its amount is 1. Any other amount, and every left shift, raises `illegal`.
- R9: Without the multiplier, code 2 raises `illegal` in both formats. Without the sign extender, codes 44 and 55 raise `illegal`. Other operations behave the same whatever the feature settings.
- R10: A register-register and (opcode 40) with bits 25:11 all zero raises `halt` and writes nothing. The same opcode with any of these fields nonzero is an ordinary and.
- R11: The unsigned divide (opcode 35) and unsigned remainder (opcode 49) never write a register from this stage. With a zero second operand they raise `div_zero`. Without the divider they raise `illegal` instead.
- R12: Opcodes 39, 42, 51 and 53 raise `illegal`. Any raised `illegal` suppresses the write. At most one flag is ever set.
- R13: Opcode 50 writes the first operand minus the second. Opcode 44 writes the first operand sign-extended from bit 7. Opcode 55 writes it sign-extended from bit 15.
- R14: Loads, stores, branches, calls and control-register opcodes produce no write and no flag. An example is code 10 in the immediate format (a load). Another is code 17 in the immediate format (a branch).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr | input | 32 | Instruction word |
| src_a | input | 32 | Value of the register named by bits 25:21 |
| src_b | input | 32 | Value of the register named by bits 20:16 |
| wr_idx | output | 5 | Destination register index |
| wr_en | output | 1 | Write the result to `wr_idx` |
| result | output | 32 | Operation result |
| illegal | output | 1 | Illegal-instruction trap |
| halt | output | 1 | Halt request |
| div_zero | output | 1 | Divide-by-zero trap |

## Verification
The bench targets the immediate-extension split:
- Chosen values make a sign-extended and a zero-extended immediate give different answers. A design that extends the wrong way returns the wrong result or the wrong compare bit.

It exercises the shifter-less instance with shift amounts of 1 and of other values:
- The register-form amount is taken from an operand whose upper bits are nonzero. A design that checks the whole operand, or ignores the gating, traps on a legal shift or lets an illegal one through.

It aims at these corner cases:
- The all-zero and that means halt, next to a near-identical ordinary and.
- Divides with and without a zero divisor, in instances with and without the divider.
- A write aimed at register 0.

A design that mixes these up asserts the wrong flag, or writes a register it must leave alone. A sweep of the whole register-register table confirms that exactly the four reserved codes trap.

// File: rtl/int_exec_stage.sv
module int_exec_stage #(
  parameter bit HAS_MUL   = 1'b1,
  parameter bit HAS_SHIFT = 1'b1,
  parameter bit HAS_SEXT  = 1'b1,
  parameter bit HAS_DIV   = 1'b1
) (
  input  logic [31:0] instr,
  input  logic [31:0] src_a,
  input  logic [31:0] src_b,
  output logic [4:0]  wr_idx,
  output logic        wr_en,
  output logic [31:0] result,
  output logic        illegal,
  output logic        halt,
  output logic        div_zero
);
  localparam logic [4:0] C_SHR_L = 5'd0,  C_NOR  = 5'd1,  C_MUL  = 5'd2,  C_DIV   = 5'd3;
  localparam logic [4:0] C_SHR_A = 5'd5,  C_XOR  = 5'd6,  C_RSV7 = 5'd7,  C_AND   = 5'd8;
  localparam logic [4:0] C_XNOR  = 5'd9,  C_RSVA = 5'd10, C_EXTB = 5'd12, C_ADD   = 5'd13;
  localparam logic [4:0] C_OR    = 5'd14, C_SHL  = 5'd15, C_REM  = 5'd17, C_SUB   = 5'd18;
  localparam logic [4:0] C_RSVU  = 5'd19, C_RSVL = 5'd21, C_EXTH = 5'd23, C_ANDHI = 5'd24;
  localparam logic [4:0] C_EQ    = 5'd25, C_GT   = 5'd26, C_GE   = 5'd27, C_GEU   = 5'd28;
  localparam logic [4:0] C_GTU   = 5'd29, C_ORHI = 5'd30, C_NE   = 5'd31;

  logic        is_rr;
  logic [4:0]  code, shamt;
  logic [31:0] imm_s, imm_z, imm_h, opb;
  logic        writes, is_cmp;

  assign is_rr  = instr[31];
  assign code   = instr[30:26];
  assign wr_idx = is_rr ? instr[15:11] : instr[20:16];
  assign imm_s  = {{16{instr[15]}}, instr[15:0]};
  assign imm_z  = {16'h0000, instr[15:0]};
  assign imm_h  = {instr[15:0], 16'h0000};
  assign shamt  = is_rr ? src_b[4:0] : instr[4:0];
  assign is_cmp = (code == C_EQ) || (code == C_GT) || (code == C_GE) ||
                  (code == C_GEU) || (code == C_GTU) || (code == C_NE);

  always_comb begin
    if (is_rr)
      opb = src_b;
    else if (code == C_ADD || code == C_MUL || code == C_EQ || code == C_GT ||
             code == C_GE || code == C_NE)
      opb = imm_s;
    else
      opb = imm_z;
  end

  always_comb begin
    result   = '0;
    writes   = 1'b0;
    illegal  = 1'b0;
    halt     = 1'b0;
    div_zero = 1'b0;
    unique case (code)
      C_SHR_L: begin
        writes = 1'b1;
        result = src_a >> shamt;
        if (!HAS_SHIFT && shamt != 5'd1) illegal = 1'b1;
      end
      C_SHR_A: begin
        writes = 1'b1;
        result = $signed(src_a) >>> shamt;
        if (!HAS_SHIFT && shamt != 5'd1) illegal = 1'b1;
      end
      C_SHL: begin
        writes = 1'b1;
        result = src_a << shamt;
        if (!HAS_SHIFT) illegal = 1'b1;
      end
      C_NOR:  begin writes = 1'b1; result = ~(src_a | opb); end
      C_XOR:  begin writes = 1'b1; result = src_a ^ opb; end
      C_XNOR: begin writes = 1'b1; result = ~(src_a ^ opb); end
      C_OR:   begin writes = 1'b1; result = src_a | opb; end
      C_ADD:  begin writes = 1'b1; result = src_a + opb; end
      C_AND: begin
        if (is_rr && instr[25:11] == 15'd0) halt = 1'b1;
        else begin writes = 1'b1; result = src_a & opb; end
      end
      C_MUL: begin
        writes = 1'b1;
        result = src_a * opb;
        if (!HAS_MUL) illegal = 1'b1;
      end
      C_EQ:  begin writes = 1'b1; result = {31'd0, src_a == opb}; end
      C_NE:  begin writes = 1'b1; result = {31'd0, src_a != opb}; end
      C_GT:  begin writes = 1'b1; result = {31'd0, $signed(src_a) > $signed(opb)}; end
      C_GE:  begin writes = 1'b1; result = {31'd0, $signed(src_a) >= $signed(opb)}; end
      C_GTU: begin writes = 1'b1; result = {31'd0, src_a > opb}; end
      C_GEU: begin writes = 1'b1; result = {31'd0, src_a >= opb}; end
      C_ANDHI: if (!is_rr) begin writes = 1'b1; result = src_a & imm_h; end
      C_ORHI:  if (!is_rr) begin writes = 1'b1; result = src_a | imm_h; end
      C_DIV, C_REM: if (is_rr) begin
        if (!HAS_DIV) illegal = 1'b1;
        else if (src_b == 32'd0) div_zero = 1'b1;
      end
      C_SUB: if (is_rr) begin writes = 1'b1; result = src_a - src_b; end
      C_EXTB: if (is_rr) begin
        writes = 1'b1;
        result = {{24{src_a[7]}}, src_a[7:0]};
        if (!HAS_SEXT) illegal = 1'b1;
      end
      C_EXTH: if (is_rr) begin
        writes = 1'b1;
        result = {{16{src_a[15]}}, src_a[15:0]};
        if (!HAS_SEXT) illegal = 1'b1;
      end
      C_RSV7, C_RSVA, C_RSVU, C_RSVL: if (is_rr) illegal = 1'b1;
      default: ;
    endcase
  end

  assign wr_en = writes && !illegal && (wr_idx != 5'd0);

  always_comb begin
    p_no_write_r0_r2:       assert (!wr_en || wr_idx != 5'd0);
    p_one_flag_r12:         assert ($onehot0({illegal, halt, div_zero}));
    p_trap_blocks_write_r12: assert (!illegal || !wr_en);
    p_zero_divisor_r11:     assert (!div_zero || (src_b == 32'd0 && is_rr && !wr_en));
    p_halt_fields_r10:      assert (!halt || (instr[25:11] == 15'd0 && !wr_en));
    p_cmp_is_bit_r6:        assert (!(wr_en && is_cmp) || result[31:1] == 31'd0);
  end
endmodule

// File: tb/tb_int_exec_stage.sv
module tb_int_exec_stage;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [31:0] instr = '0, src_a = '0, src_b = '0;
  logic [4:0]  f_idx, l_idx;
  logic        f_we, l_we, f_ill, l_ill, f_hlt, l_hlt, f_dz, l_dz;
  logic [31:0] f_res, l_res;

  int_exec_stage dut (.instr(instr), .src_a(src_a), .src_b(src_b), .wr_idx(f_idx), .wr_en(f_we),
    .result(f_res), .illegal(f_ill), .halt(f_hlt), .div_zero(f_dz));
  int_exec_stage #(.HAS_MUL(1'b0), .HAS_SHIFT(1'b0), .HAS_SEXT(1'b0), .HAS_DIV(1'b0)) dut_lite (
    .instr(instr), .src_a(src_a), .src_b(src_b), .wr_idx(l_idx), .wr_en(l_we),
    .result(l_res), .illegal(l_ill), .halt(l_hlt), .div_zero(l_dz));

  typedef struct packed {
    logic lite; logic [31:0] ins, a, b; logic [4:0] idx; logic we, chk;
    logic [31:0] res; logic [2:0] flg; logic [3:0] req;
  } vec_t;

  function automatic logic [31:0] ri(int op, int s, int d, logic [15:0] imm);
    return {op[5:0], s[4:0], d[4:0], imm};
  endfunction
  function automatic logic [31:0] rr(int op, int s, int t, int d);
    return {op[5:0], s[4:0], t[4:0], d[4:0], 11'd0};
  endfunction
  function automatic vec_t mk(int lite, logic [31:0] ins, logic [31:0] a, logic [31:0] b, int idx,
                              int we, int chk, logic [31:0] res, int flg, int req);
    vec_t v;
    v.lite = lite[0]; v.ins = ins; v.a = a; v.b = b; v.idx = idx[4:0]; v.we = we[0];
    v.chk = chk[0]; v.res = res; v.flg = flg[2:0]; v.req = req[3:0];
    return v;
  endfunction

  // flags field: {illegal, halt, div_zero}
  localparam vec_t VECS [44] = '{
    mk(0, ri(13,1,3,16'hFFFF), 32'd5, 32'd0, 3, 1,1, 32'd4, 0, 3),                    // R3 addi
    mk(0, rr(45,1,2,7), 32'd10, 32'd20, 7, 1,1, 32'd30, 0, 1),                        // R1 add rr
    mk(0, ri(8,1,4,16'h8F0F), 32'hFFFF_FFFF, 32'd0, 4, 1,1, 32'h0000_8F0F, 0, 4),     // R4 andi
    mk(0, ri(14,2,5,16'h8000), 32'h1234_0000, 32'd0, 5, 1,1, 32'h1234_8000, 0, 4),    // R4 ori
    mk(0, ri(9,1,6,16'h00FF), 32'd0, 32'd0, 6, 1,1, 32'hFFFF_FF00, 0, 4),             // R4 xnori
    mk(0, ri(1,1,6,16'h0F00), 32'h0000_00F0, 32'd0, 6, 1,1, 32'hFFFF_F00F, 0, 4),     // R4 nori
    mk(0, ri(24,1,8,16'hABCD), 32'hFFFF_FFFF, 32'd0, 8, 1,1, 32'hABCD_0000, 0, 5),    // R5 and-high
    mk(0, ri(30,0,9,16'h1234), 32'h0000_0055, 32'd0, 9, 1,1, 32'h1234_0055, 0, 5),    // R5 or-high
    mk(0, ri(26,1,10,16'hFFFE), 32'hFFFF_FFFF, 32'd0, 10, 1,1, 32'd1, 0, 6),          // R6 signed gt imm
    mk(0, ri(29,1,10,16'hFFFE), 32'h0001_0000, 32'd0, 10, 1,1, 32'd1, 0, 4),          // R4 gtu zext
    mk(0, rr(59,1,2,11), 32'h8000_0000, 32'd1, 11, 1,1, 32'd0, 0, 6),                 // R6 ge signed
    mk(0, rr(60,1,2,11), 32'h8000_0000, 32'd1, 11, 1,1, 32'd1, 0, 6),                 // R6 geu
    mk(0, rr(63,1,2,12), 32'd7, 32'd7, 12, 1,1, 32'd0, 0, 6),                         // R6 ne
    mk(0, ri(25,1,12,16'hFFFF), 32'hFFFF_FFFF, 32'd0, 12, 1,1, 32'd1, 0, 3),          // R3 eq sext
    mk(0, rr(37,1,2,13), 32'h8000_0000, 32'h24, 13, 1,1, 32'hF800_0000, 0, 7),        // R7 sr
    mk(0, rr(32,1,2,13), 32'h8000_0000, 32'h24, 13, 1,1, 32'h0800_0000, 0, 7),        // R7 sru
    mk(0, ri(15,1,14,16'h0008), 32'h0000_00FF, 32'd0, 14, 1,1, 32'h0000_FF00, 0, 7),  // R7 sl imm
    mk(0, ri(2,1,15,16'hFFFD), 32'd7, 32'd0, 15, 1,1, 32'hFFFF_FFEB, 0, 3),           // R3 muli
    mk(0, rr(50,1,2,16), 32'd5, 32'd7, 16, 1,1, 32'hFFFF_FFFE, 0, 13),                // R13 sub
    mk(0, rr(44,1,0,17), 32'h0000_0080, 32'd0, 17, 1,1, 32'hFFFF_FF80, 0, 13),        // R13 sext byte
    mk(0, rr(55,1,0,17), 32'hFFFF_7FFF, 32'd0, 17, 1,1, 32'h0000_7FFF, 0, 13),        // R13 sext half
    mk(0, ri(13,1,0,16'h0005), 32'd1, 32'd0, 0, 0,0, 32'd0, 0, 2),                    // R2 to r0
    mk(0, rr(40,0,0,0), 32'd3, 32'd5, 0, 0,0, 32'd0, 2, 10),                          // R10 halt
    mk(0, rr(40,0,0,3), 32'd3, 32'd5, 3, 1,1, 32'd1, 0, 10),                          // R10 plain and
    mk(0, rr(35,1,2,3), 32'd9, 32'd0, 3, 0,0, 32'd0, 1, 11),                          // R11 divu zero
    mk(0, rr(35,1,2,3), 32'd9, 32'd3, 3, 0,0, 32'd0, 0, 11),                          // R11 divu ok
    mk(0, rr(49,1,2,4), 32'd9, 32'd0, 4, 0,0, 32'd0, 1, 11),                          // R11 modu zero
    mk(0, rr(39,1,2,3), 32'd1, 32'd1, 3, 0,0, 32'd0, 4, 12),                          // R12 reserved
    mk(0, rr(51,1,2,3), 32'd1, 32'd1, 3, 0,0, 32'd0, 4, 12),                          // R12 reserved
    mk(0, ri(10,1,2,16'h0004), 32'd1, 32'd1, 2, 0,0, 32'd0, 0, 14),                   // R14 load
    mk(0, ri(17,1,2,16'h0004), 32'd1, 32'd1, 2, 0,0, 32'd0, 0, 14),                   // R14 branch
    mk(0, ri(13,0,5,16'h1800), 32'd0, 32'd0, 5, 1,1, 32'h0000_1800, 0, 1),            // R1 RI dest
    mk(0, rr(32,1,2,13), 32'h8000_0004, 32'hFFFF_FFE1, 13, 1,1, 32'h4000_0002, 0, 7), // R7 low 5 bits
    mk(1, ri(5,1,2,16'h0001), 32'h8000_0002, 32'd0, 2, 1,1, 32'hC000_0001, 0, 8),     // R8 sr by 1
    mk(1, ri(5,1,2,16'h0002), 32'h8000_0002, 32'd0, 2, 0,0, 32'd0, 4, 8),             // R8 sr by 2
    mk(1, rr(32,1,2,3), 32'd8, 32'h21, 3, 1,1, 32'd4, 0, 8),                          // R8 sru by 1
    mk(1, rr(32,1,2,3), 32'd8, 32'd3, 3, 0,0, 32'd0, 4, 8),                           // R8 sru by 3
    mk(1, ri(15,1,2,16'h0001), 32'd8, 32'd0, 2, 0,0, 32'd0, 4, 8),                    // R8 sl
    mk(1, ri(2,1,2,16'h0003), 32'd8, 32'd0, 2, 0,0, 32'd0, 4, 9),                     // R9 muli
    mk(1, rr(34,1,2,3), 32'd8, 32'd2, 3, 0,0, 32'd0, 4, 9),                           // R9 mul
    mk(1, rr(44,1,0,3), 32'h80, 32'd0, 3, 0,0, 32'd0, 4, 9),                          // R9 sextb
    mk(1, rr(55,1,0,3), 32'h8000, 32'd0, 3, 0,0, 32'd0, 4, 9),                        // R9 sexth
    mk(1, rr(35,1,2,3), 32'd9, 32'd0, 3, 0,0, 32'd0, 4, 11),                          // R11 no divider
    mk(1, rr(45,1,2,3), 32'd1, 32'd2, 3, 1,1, 32'd3, 0, 9)                            // R9 add unaffected
  };

  int total = 0, bad = 0;
  bit done = 1'b0;

  task automatic check(bit ok, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(!f_we && {f_ill, f_hlt, f_dz} == 3'b000, "reset-state R2 idle word",
          {f_we, f_ill, f_hlt, f_dz}, 4'b0000);
    rst = 1'b0;

    for (int i = 0; i < 44; i++) begin
      vec_t v;
      logic [4:0] idx; logic we; logic [31:0] res; logic [2:0] flg;
      v = VECS[i];
      @(negedge clk);
      instr = v.ins; src_a = v.a; src_b = v.b;
      #1;
      idx = v.lite ? l_idx : f_idx;
      we  = v.lite ? l_we : f_we;
      res = v.lite ? l_res : f_res;
      flg = v.lite ? {l_ill, l_hlt, l_dz} : {f_ill, f_hlt, f_dz};
      check(idx == v.idx && we == v.we && flg == v.flg && (!v.chk || res == v.res),
            $sformatf("R%0d vector %0d idx/we/flags/result", v.req, i),
            {idx, we, flg, res}, {v.idx, v.we, v.flg, v.chk ? v.res : res});
    end

    // R12: sweep of register-register table, only the four reserved codes trap
    for (int op = 32; op < 64; op++) begin
      bit exp_ill;
      @(negedge clk);
      instr = rr(op, 1, 2, 3); src_a = 32'd1; src_b = 32'd1;
      #1;
      exp_ill = (op == 39) || (op == 42) || (op == 51) || (op == 53);
      check(f_ill == exp_ill, $sformatf("R12 sweep opcode %0d illegal", op), f_ill, exp_ill);
    end

    // R2: dest r0 for a writing op in both formats
    @(negedge clk);
    instr = rr(45, 1, 2, 0); src_a = 32'd4; src_b = 32'd4;
    #1;
    check(!f_we && f_idx == 5'd0, "R2 rr add to r0", {f_idx, f_we}, 6'd0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule